// File: doc/BRIEF.md
# Programmable CRC-32 Accumulator

This unit keeps a running 32-bit CRC and folds new data into it under command. Software, or a neighbouring engine, loads a generator polynomial, a starting value and an optional byte count. It then issues update commands that carry a 64-bit word. Each update command picks how many low-order bytes of the word to consume: 1, 2, 4 or 8 bytes, or the count held in the length register. It also picks the bit order. Normal order shifts toward the most significant bit. Reflected order shifts toward the least significant bit.

Only one state register exists, and both bit orders share it. A reflected update reverses the bits inside each byte of the stored state. It works on that view with the byte-swapped polynomial, then maps the result back the same way. Two dedicated commands move the state in and out in the reflected view. An unrolled datapath folds one byte per clock. While bytes remain, the unit raises `busy` and drops `req_ready`, and a pending command waits.

Top module: `crc32_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the state, polynomial and length registers and `rd_data` to zero. It also abandons any update in progress: after that edge `busy` is 0 and `req_ready` is 1.
- R2: Plain writes: opcode 1 loads the state from `req_wdata[31:0]`, opcode 2 loads the polynomial from `req_wdata[31:0]`, and opcode 3 loads the length from `req_wdata[31:0]`. Plain reads: opcode 5 returns the state, 6 the polynomial and 7 the length, each zero-extended to 64 bits. `rd_data` is registered. It changes only at the edge that accepts a read command and holds its value otherwise.
- R3: Normal update, where opcode bit 4 is 1 and bit 3 is 0. Each consumed byte is XORed into state bits 31:24. Eight left shifts follow, and each shift XORs in the polynomial when bit 31 was 1 before that shift.
- R4: Opcode bits 2:0 give the byte count N: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. The bytes consumed are `req_wdata[8N-1:0]`, highest byte first. Bytes above them have no effect.
- R5: Reflected update, where opcode bits 4 and 3 are both 1. The working value is the stored state with the bits of each byte reversed in place. The working polynomial is the polynomial with its four bytes swapped. Each byte is XORed into working bits 7:0. Eight right shifts follow, and each shift XORs in the swapped polynomial when bit 0 was 1 before that shift. The result is stored after the same per-byte bit reversal.
- R6: Size code 4 takes N from the low 4 bits of the length register, capped at 8. When N is 0 the state is unchanged and `busy` stays 0.
- R7: Opcode 4 stores the per-byte bit reversal of `req_wdata[31:0]`. Opcode 8 returns the per-byte bit reversal of the state, zero-extended.
- R8: After an accepted update with N>0, `busy` is 1 for exactly N cycles starting the next cycle, and `req_ready` is 0 whenever `busy` is 1. The final state is readable as soon as `busy` falls.
- R9: A command presented while `busy` is 1 is held off and accepted only after the update finishes. A polynomial write held this way does not alter the update in flight.
- R10: With polynomial 0x2083B8ED and reflected state 0xFFFFFFFF, a reflected 8-byte update of 0x3132333435363738 followed by a reflected 1-byte update of 0x39 leaves a reflected state of 0x340BC6D9.
- R11: Opcodes 0 and 9 to 15, and update size codes 5 to 7, change no register and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command present |
| req_op | input | 5 | Command opcode |
| req_wdata | input | 64 | Write data or update data |
| req_ready | output | 1 | Command accepted at this edge when high together with `req_valid` |
| rd_data | output | 64 | Registered read result |
| busy | output | 1 | Update bytes remain to be folded |

## Verification
The hardest case to reach is a command arriving while an update is still folding bytes. A new write must be held off, and a polynomial change must not leak into the bytes still in flight. The bench starts an 8-byte update and presents a polynomial write on the very next cycle. It keeps that request asserted across the busy window, then compares the state with a model that used the old polynomial. A reset landing mid-update, and a variable-length update whose length nibble is zero or above eight, are driven the same way through the normal command port.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int CRC_W   = 32;
  localparam int DATA_W  = 64;
  localparam int NBYTES  = DATA_W / 8;
  localparam int CNT_W   = $clog2(NBYTES + 1);
  localparam int OP_W    = 5;

  localparam logic [OP_W-1:0] OP_WR_STATE    = 5'd1;
  localparam logic [OP_W-1:0] OP_WR_POLY     = 5'd2;
  localparam logic [OP_W-1:0] OP_WR_LEN      = 5'd3;
  localparam logic [OP_W-1:0] OP_WR_STATE_RF = 5'd4;
  localparam logic [OP_W-1:0] OP_RD_STATE    = 5'd5;
  localparam logic [OP_W-1:0] OP_RD_POLY     = 5'd6;
  localparam logic [OP_W-1:0] OP_RD_LEN      = 5'd7;
  localparam logic [OP_W-1:0] OP_RD_STATE_RF = 5'd8;

  // reverse bit order inside each byte, bytes stay in place
  function automatic logic [CRC_W-1:0] rev_in_bytes(input logic [CRC_W-1:0] x);
    logic [CRC_W-1:0] r;
    for (int b = 0; b < CRC_W / 8; b++)
      for (int i = 0; i < 8; i++)
        r[8*b + i] = x[8*b + 7 - i];
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] swap_bytes(input logic [CRC_W-1:0] x);
    logic [CRC_W-1:0] r;
    for (int b = 0; b < CRC_W / 8; b++)
      r[8*b +: 8] = x[8*(CRC_W/8 - 1 - b) +: 8];
    return r;
  endfunction

  // one shift toward bit 31
  function automatic logic [CRC_W-1:0] shl_step(input logic [CRC_W-1:0] c,
                                                input logic [CRC_W-1:0] p);
    return c[CRC_W-1] ? ((c << 1) ^ p) : (c << 1);
  endfunction

  // one shift toward bit 0
  function automatic logic [CRC_W-1:0] shr_step(input logic [CRC_W-1:0] c,
                                                input logic [CRC_W-1:0] p);
    return c[0] ? ((c >> 1) ^ p) : (c >> 1);
  endfunction

  // size code to byte count; code 4 reads the length nibble
  function automatic logic [CNT_W-1:0] size_to_count(input logic [2:0] code,
                                                     input logic [3:0] len_lo);
    logic [CNT_W-1:0] n;
    case (code)
      3'd0: n = CNT_W'(1);
      3'd1: n = CNT_W'(2);
      3'd2: n = CNT_W'(4);
      3'd3: n = CNT_W'(8);
      3'd4: n = (len_lo > 4'd8) ? CNT_W'(8) : CNT_W'(len_lo);
      default: n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/crc32_step.sv
module crc32_step
  import crc32_pkg::*;
(
  input  logic [CRC_W-1:0] state_in,
  input  logic [CRC_W-1:0] poly_in,
  input  logic [7:0]       din,
  input  logic             reflect,
  output logic [CRC_W-1:0] state_out
);
  logic [CRC_W-1:0] work_in;
  logic [CRC_W-1:0] poly_eff;
  logic [CRC_W-1:0] stage [0:8];

  assign work_in  = reflect ? rev_in_bytes(state_in) : state_in;
  assign poly_eff = reflect ? swap_bytes(poly_in) : poly_in;
  assign stage[0] = reflect ? (work_in ^ {{(CRC_W-8){1'b0}}, din})
                            : (work_in ^ {din, {(CRC_W-8){1'b0}}});

  for (genvar k = 0; k < 8; k++) begin : g_shift
    assign stage[k+1] = reflect ? shr_step(stage[k], poly_eff)
                                : shl_step(stage[k], poly_eff);
  end

  assign state_out = reflect ? rev_in_bytes(stage[8]) : stage[8];
endmodule

// File: rtl/crc32_seq.sv
module crc32_seq
  import crc32_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_refl,
  output logic [7:0]        cur_byte,
  output logic              cur_refl,
  output logic              fold_fire
);
  localparam int SH_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  remain;
  logic [SH_W-1:0]   align_sh;

  // move the top consumed byte to the top of the shift register
  always_comb align_sh = SH_W'((NBYTES - int'(load_cnt)) * 8);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      remain   <= '0;
      cur_refl <= 1'b0;
    end else if (load) begin
      shreg    <= load_data << align_sh;
      remain   <= load_cnt;
      cur_refl <= load_refl;
    end else if (fold_fire) begin
      shreg    <= shreg << 8;
      remain   <= remain - CNT_W'(1);
    end
  end

  assign fold_fire = (remain != '0);
  assign cur_byte  = shreg[DATA_W-1 -: 8];
endmodule

// File: rtl/crc32_unit.sv
module crc32_unit
  import crc32_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [4:0]        req_op,
  input  logic [63:0]       req_wdata,
  output logic              req_ready,
  output logic [63:0]       rd_data,
  output logic              busy
);
  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] poly_q;
  logic [LEN_W-1:0] len_q;

  logic             acc;
  logic             upd_acc;
  logic [CNT_W-1:0] upd_cnt;
  logic             fold_fire;
  logic             cur_refl;
  logic [7:0]       cur_byte;
  logic [CRC_W-1:0] step_next;

  assign req_ready = !fold_fire;
  assign busy      = fold_fire;
  assign acc       = req_valid && req_ready;
  assign upd_acc   = acc && req_op[4];
  assign upd_cnt   = size_to_count(req_op[2:0], len_q[3:0]);

  crc32_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (upd_acc),
    .load_cnt  (upd_cnt),
    .load_data (req_wdata),
    .load_refl (req_op[3]),
    .cur_byte  (cur_byte),
    .cur_refl  (cur_refl),
    .fold_fire (fold_fire)
  );

  crc32_step u_step (
    .state_in  (state_q),
    .poly_in   (poly_q),
    .din       (cur_byte),
    .reflect   (cur_refl),
    .state_out (step_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      poly_q  <= '0;
      len_q   <= '0;
    end else if (fold_fire) begin
      state_q <= step_next;
    end else if (acc) begin
      case (req_op)
        OP_WR_STATE:    state_q <= req_wdata[CRC_W-1:0];
        OP_WR_STATE_RF: state_q <= rev_in_bytes(req_wdata[CRC_W-1:0]);
        OP_WR_POLY:     poly_q  <= req_wdata[CRC_W-1:0];
        OP_WR_LEN:      len_q   <= req_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (acc) begin
      case (req_op)
        OP_RD_STATE:    rd_data <= 64'(state_q);
        OP_RD_POLY:     rd_data <= 64'(poly_q);
        OP_RD_LEN:      rd_data <= 64'(len_q);
        OP_RD_STATE_RF: rd_data <= 64'(rev_in_bytes(state_q));
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc32_unit_chk.sv
module crc32_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [4:0]  req_op,
  input logic        busy,
  input logic        upd_acc,
  input logic [3:0]  upd_cnt,
  input logic [31:0] state_q,
  input logic [31:0] poly_q,
  input logic [63:0] rd_data
);
  logic [3:0] run_cnt;
  logic       rd_acc;
  logic       st_wr_acc;

  assign rd_acc    = req_valid && req_ready && (req_op >= 5'd5) && (req_op <= 5'd8);
  assign st_wr_acc = req_valid && req_ready && (req_op == 5'd1 || req_op == 5'd4);

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 4'd1;
    else           run_cnt <= '0;
  end

  a_r8_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  a_r8_busy_after_upd: assert property (@(posedge clk) disable iff (rst)
    (upd_acc && upd_cnt != 4'd0) |=> busy);

  a_r8_busy_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < 4'd8));

  a_r6_zero_count_idle: assert property (@(posedge clk) disable iff (rst)
    (upd_acc && upd_cnt == 4'd0) |=> (!busy && $stable(state_q)));

  a_r9_poly_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(poly_q));

  a_r2_state_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !st_wr_acc) |=> $stable(state_q));

  a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(rd_data));
endmodule

bind crc32_unit crc32_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .busy      (busy),
  .upd_acc   (upd_acc),
  .upd_cnt   (upd_cnt),
  .state_q   (state_q),
  .poly_q    (poly_q),
  .rd_data   (rd_data)
);

// File: tb/crc32_unit_tb.sv
module crc32_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_op = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready;
  logic [63:0] rd_data;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_state = '0, m_poly = '0, m_len = '0;

  always #5 clk = ~clk;

  crc32_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data), .busy(busy)
  );

  localparam int NV = 18;
  localparam logic [68:0] VECS [NV] = '{
    {5'd2,  64'h0000_0000_04C1_1DB7},
    {5'd1,  64'h0000_0000_FFFF_FFFF},
    {5'd16, 64'hDEAD_BEEF_CAFE_12AB},
    {5'd17, 64'h1111_2222_3333_A55A},
    {5'd18, 64'h9999_8888_0123_4567},
    {5'd19, 64'h0011_2233_4455_6677},
    {5'd3,  64'h0000_0000_0000_0005},
    {5'd20, 64'hFEDC_BA98_7654_3210},
    {5'd3,  64'h0000_0000_0000_001C},
    {5'd20, 64'h0F1E_2D3C_4B5A_6978},
    {5'd2,  64'h0000_0000_2083_B8ED},
    {5'd4,  64'h0000_0000_89AB_CDEF},
    {5'd24, 64'h7777_7777_7777_77C3},
    {5'd25, 64'h5555_5555_5555_1234},
    {5'd26, 64'hAAAA_AAAA_DEAD_BEEF},
    {5'd27, 64'h8040_2010_0804_0201},
    {5'd3,  64'h0000_0000_0000_0003},
    {5'd28, 64'h0000_0000_00AB_CDEF}
  };

  function automatic logic [31:0] m_map(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[(i/8)*8 + 7 - (i%8)] = x[i];
    return r;
  endfunction

  function automatic logic [31:0] m_bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic int m_count(input logic [4:0] op, input logic [31:0] len);
    case (op[2:0])
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return (len[3:0] > 8) ? 8 : int'(len[3:0]);
      default: return 0;
    endcase
  endfunction

  // bit-serial reference: data bit enters the feedback directly
  task automatic m_apply(input logic [4:0] op, input logic [63:0] d);
    if (op[4]) begin
      int n = m_count(op, m_len);
      logic [31:0] w = op[3] ? m_map(m_state) : m_state;
      logic [31:0] p = op[3] ? m_bswap(m_poly) : m_poly;
      for (int k = n - 1; k >= 0; k--) begin
        logic [7:0] b = d[8*k +: 8];
        for (int j = 0; j < 8; j++) begin
          logic fb;
          if (op[3]) begin
            fb = w[0] ^ b[j];
            w = w >> 1;
          end else begin
            fb = w[31] ^ b[7-j];
            w = w << 1;
          end
          if (fb) w = w ^ p;
        end
      end
      m_state = op[3] ? m_map(w) : w;
    end else begin
      case (op)
        5'd1: m_state = d[31:0];
        5'd2: m_poly  = d[31:0];
        5'd3: m_len   = d[31:0];
        5'd4: m_state = m_map(d[31:0]);
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_op = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run(input logic [4:0] op, input logic [63:0] d);
    issue(op, d);
    m_apply(op, d);
    wait_idle();
  endtask

  task automatic rd(input logic [4:0] op, output logic [63:0] v);
    issue(op, 64'hFFFF_FFFF_FFFF_FFFF);
    v = rd_data;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [63:0] v;
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 ready after reset", 64'(req_ready), 64'd1);
    check("R1 busy after reset", 64'(busy), 64'd0);
    rd(5'd5, v); check("R1 state zero", v, 64'd0);
    rd(5'd6, v); check("R1 poly zero", v, 64'd0);
    rd(5'd7, v); check("R1 len zero", v, 64'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      logic [4:0]  op = VECS[i][68:64];
      logic [63:0] d  = VECS[i][63:0];
      run(op, d);
      rd(5'd5, v); check($sformatf("R3/R4/R5/R6 vec %0d state", i), v, 64'(m_state));
      rd(5'd8, v); check($sformatf("R7 vec %0d reflected read", i), v, 64'(m_map(m_state)));
    end
    rd(5'd6, v); check("R2 poly readback", v, 64'(m_poly));
    rd(5'd7, v); check("R2 len readback", v, 64'(m_len));

    // R6 length nibble zero (upper bits set): no change
    run(5'd3, 64'h0000_0000_0000_0010);
    run(5'd20, 64'h1234_5678_9ABC_DEF0);
    rd(5'd5, v); check("R6 zero count unchanged", v, 64'(m_state));

    // R11 undefined size codes and opcodes
    run(5'd21, 64'h1234);
    run(5'd31, 64'h5678);
    run(5'd12, 64'hFFFF_FFFF);
    run(5'd0,  64'hFFFF_FFFF);
    rd(5'd5, v); check("R11 undefined ops no effect", v, 64'(m_state));
    rd(5'd6, v); check("R11 poly untouched", v, 64'(m_poly));

    // R7 literal mapping
    run(5'd4, 64'hFFFF_FFFF_1234_5678);
    rd(5'd5, v); check("R7 reflected write stored", v, 64'h0000_0000_482C_6A1E);

    // R10 standard check value
    run(5'd2, 64'h2083_B8ED);
    run(5'd4, 64'hFFFF_FFFF);
    run(5'd27, 64'h3132_3334_3536_3738);
    run(5'd24, 64'h39);
    rd(5'd8, v); check("R10 check value", v, 64'h0000_0000_340B_C6D9);
    check("R10 model agrees", 64'(m_map(m_state)), 64'h0000_0000_340B_C6D9);

    // R8 busy length for 4 bytes and variable 8 bytes
    issue(5'd18, 64'hA1B2_C3D4); m_apply(5'd18, 64'hA1B2_C3D4);
    check("R8 ready low while busy", 64'(req_ready), 64'd0);
    cyc = 0; while (busy) begin cyc++; @(negedge clk); end
    check("R8 busy cycles 4B", 64'(cyc), 64'd4);
    run(5'd3, 64'h8);
    issue(5'd20, 64'h0102_0304_0506_0708); m_apply(5'd20, 64'h0102_0304_0506_0708);
    cyc = 0; while (busy) begin cyc++; @(negedge clk); end
    check("R8 busy cycles var 8", 64'(cyc), 64'd8);
    rd(5'd5, v); check("R8 state after busy", v, 64'(m_state));

    // R9 poly write held while busy
    run(5'd2, 64'h04C1_1DB7);
    issue(5'd19, 64'hCAFE_F00D_DEAD_BEEF); m_apply(5'd19, 64'hCAFE_F00D_DEAD_BEEF);
    req_valid = 1'b1; req_op = 5'd2; req_wdata = 64'h1EDC_6F41;
    check("R9 stalled ready", 64'(req_ready), 64'd0);
    while (!req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_op = '0;
    m_apply(5'd2, 64'h1EDC_6F41);
    rd(5'd5, v); check("R9 update used old poly", v, 64'(m_state));
    rd(5'd6, v); check("R9 held write landed", v, 64'h1EDC_6F41);

    // R1 reset mid-update
    issue(5'd19, 64'h0123_4567_89AB_CDEF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 busy cleared mid-run", 64'(busy), 64'd0);
    check("R1 ready after mid reset", 64'(req_ready), 64'd1);
    check("R1 rd_data cleared", rd_data, 64'd0);
    rst = 1'b0;
    rd(5'd5, v); check("R1 state cleared mid-run", v, 64'd0);
    rd(5'd6, v); check("R1 poly cleared mid-run", v, 64'd0);

    done = 1'b1;
    summary();
  end
endmodule